// File: doc/BRIEF.md
# MDIO Management Master

This block is a hardware master for the two-wire Ethernet PHY management channel. A host raises `start` with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. The block then produces the management clock on `mdc` and runs one complete register transaction on the data line. The bidirectional data line is handed to the pad as three signals: a drive value, a drive enable and a returned input. The returned input is resynchronised to the system clock before it is used. When the transaction is over the block pulses `done` for one cycle. For a read, it presents the captured word and a flag that reports whether a PHY answered.

Each half of the management clock lasts `HALF_PERIOD` system clock cycles. A transaction begins with a long run of ones, followed by the start and opcode bits and the two addresses. A write then drives a turnaround pattern and the data word. A read releases the line and checks the first turnaround bit. If nothing pulls that bit low, the block treats the PHY as missing. It returns all-ones data, raises the error flag, and clocks the bus for a further 32 cycles with the line released, which lets any confused PHY resynchronise.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc` is 1, `mdio_oe` is 0, `mdio_o` is 1, `busy`, `done` and `no_phy` are 0 and `rd_data` is 0.
- R2: `start` is accepted only while `busy` is 0. `busy` is 1 from the cycle after acceptance until the cycle in which `done` is 1. In that cycle `busy` is 0, and `done` is 1 for exactly one cycle. A `start`, or a change of the request inputs, while `busy` is 1 has no effect on the running frame and does not queue another one.
- R3: A bit cycle is one `mdc` low phase followed by one high phase, each exactly `HALF_PERIOD` clock cycles long. The first low phase begins at the acceptance edge.
- R4: `mdio_o` and `mdio_oe` change only at the edge where `mdc` falls or while `mdc` is low. They never change while `mdc` is high.
- R5: Bit cycles 0 to 45 of every frame are driven (`mdio_oe`=1) with the following values: 32 ones; then 0 and 1; then 1,0 for a read or 0,1 for a write; then the PHY address MSB first; then the register address MSB first.
- R6: In a write, bit cycles 46 and 47 drive 1 then 0. Cycles 48 to 63 drive the data word MSB first. Cycle 64 has `mdio_oe`=0. `done` rises 130·`HALF_PERIOD` cycles after acceptance (65 bit cycles).
- R7: In a read, `mdio_oe` is 0 from bit cycle 46 to the end. The line is sampled at the end of each high phase, through a 2-flop synchroniser, so the value must be valid at least 3 clock cycles before `mdc` falls. A low value in cycle 46 means a PHY is present. Cycles 47 to 62 then carry the data word MSB first, and cycles 63 and 64 complete the frame. `done` comes at 130·`HALF_PERIOD` cycles with `rd_data` equal to the word and `no_phy`=0.
- R8: If the line is high at the end of bit cycle 46 of a read, 32 more bit cycles follow with `mdio_oe`=0 (79 bit cycles in total). `done` comes at 158·`HALF_PERIOD` cycles with `rd_data`=16'hFFFF and `no_phy`=1.
- R9: Whenever `busy` is 0, `mdc` rests at 1 and `mdio_oe` is 0.
- R10: A completed write clears `no_phy` and leaves `rd_data` at its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a transaction (taken only when idle) |
| rd_wr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Word to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Word returned by the last read |
| no_phy | output | 1 | Last read found no responding PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value to drive on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Value seen on the data line |

## Verification
A miscounted bit index shows up quickly at the pins. A header bit lands in the wrong cycle, or the number of `mdc` rising edges per frame moves away from 65 or 79. Either is visible within one frame, and the completion latency shifts by a multiple of `2·HALF_PERIOD` cycles. A wrong phase length or a wrong turnaround decision is seen within the first bit cycle or at the 47th rising edge. A wrong capture order or a wrong sample point shows as a scrambled `rd_data` at the very next `done`.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int PHY_END    = PRE_BITS + 4 + ADDR_W;
  localparam int TA_IDX     = PHY_END + ADDR_W;
  localparam int DAT_BEG    = TA_IDX + 2;
  localparam int FRAME_BITS = DAT_BEG + DATA_W + 1;
  localparam int RD_FIRST   = TA_IDX + 1;
  localparam int RD_LAST    = RD_FIRST + DATA_W - 1;
  localparam int RECOV_BITS = 32;
  localparam int IDX_W      = $clog2(FRAME_BITS + 1);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_RECOV} seq_st_t;

  typedef struct packed {
    logic oe;
    logic val;
  } pin_t;

  localparam pin_t PIN_IDLE = '{oe: 1'b0, val: 1'b1};

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } req_t;

  // Pin state to present during bit cycle idx of a frame for request q.
  function automatic pin_t frame_pin(input req_t q, input logic [IDX_W-1:0] idx);
    pin_t p;
    int   i;
    p = '{oe: 1'b1, val: 1'b1};
    i = int'(idx);
    if (i < PRE_BITS)               p.val = 1'b1;
    else if (i == PRE_BITS)         p.val = 1'b0;
    else if (i == PRE_BITS + 1)     p.val = 1'b1;
    else if (i == PRE_BITS + 2)     p.val = q.rd;
    else if (i == PRE_BITS + 3)     p.val = !q.rd;
    else if (i < PHY_END)           p.val = q.phy[3'(PHY_END - 1 - i)];
    else if (i < TA_IDX)            p.val = q.regad[3'(TA_IDX - 1 - i)];
    else if (q.rd)                  p = PIN_IDLE;
    else if (i == TA_IDX)           p.val = 1'b1;
    else if (i == TA_IDX + 1)       p.val = 1'b0;
    else if (i < DAT_BEG + DATA_W)  p.val = q.wdata[4'(DAT_BEG + DATA_W - 1 - i)];
    else                            p = PIN_IDLE;
    return p;
  endfunction

  // Append one received bit at the LSB end (MSB arrives first).
  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] d, input logic b);
    return {d[DATA_W-2:0], b};
  endfunction
endpackage

// File: rtl/mdc_tick_gen.sv
`timescale 1ns/1ps
module mdc_tick_gen #(
  parameter int HALF_PERIOD = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || !run || tick) cnt <= '0;
    else                                cnt <= cnt + 1'b1;
  end

  // R3: the counter never runs past the end of a phase
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= LAST));
endmodule

// File: rtl/mdio_in_sync.sv
`timescale 1ns/1ps
module mdio_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int SW = (STAGES < 2) ? 2 : STAGES;

  logic [SW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[SW-2:0], d};
  end

  assign q = sh[SW-1];
endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq import mdio_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  req_t              req_in,
  input  logic              smp,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe
);
  seq_st_t           st;
  req_t              q;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  pin_t              pin;

  logic last_bit, ta_fail, in_data;

  assign mdio_o  = pin.val;
  assign mdio_oe = pin.oe;
  assign busy    = (st != ST_IDLE);
  assign accept  = start && (st == ST_IDLE);

  assign last_bit = (st == ST_RECOV) ? (idx == IDX_W'(RECOV_BITS - 1))
                                     : (idx == IDX_W'(FRAME_BITS - 1));
  assign ta_fail  = (st == ST_FRAME) && q.rd && (idx == IDX_W'(TA_IDX)) && smp;
  assign in_data  = (st == ST_FRAME) && q.rd &&
                    (idx >= IDX_W'(RD_FIRST)) && (idx <= IDX_W'(RD_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      q     <= '0;
      idx   <= '0;
      shreg <= '0;
      pin   <= PIN_IDLE;
      mdc   <= 1'b1;
      done  <= 1'b0;
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        st  <= ST_FRAME;
        q   <= req_in;
        idx <= '0;
        mdc <= 1'b0;
        pin <= frame_pin(req_in, '0);
      end else if (busy && tick) begin
        if (!mdc) begin
          mdc <= 1'b1;
        end else begin
          if (in_data) shreg <= shift_in(shreg, smp);
          if (ta_fail) begin
            st  <= ST_RECOV;
            idx <= '0;
            mdc <= 1'b0;
            pin <= PIN_IDLE;
          end else if (last_bit) begin
            st   <= ST_IDLE;
            done <= 1'b1;
            if (st == ST_RECOV) begin
              rdata <= ALL_ONES;
              err   <= 1'b1;
            end else if (q.rd) begin
              rdata <= shreg;
              err   <= 1'b0;
            end else begin
              err   <= 1'b0;
            end
          end else begin
            idx <= idx + 1'b1;
            mdc <= 1'b0;
            pin <= (st == ST_RECOV) ? PIN_IDLE : frame_pin(q, idx + 1'b1);
          end
        end
      end
    end
  end

  // R2: completion pulse lasts one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2: busy has dropped when done is shown
  a_r2_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R7: line released from the turnaround on in a read
  a_r7_read_released: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FRAME && q.rd && idx >= IDX_W'(TA_IDX)) |-> !mdio_oe);
  // R8: recovery clocks keep the line released
  a_r8_recov_released: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RECOV) |-> !mdio_oe);
  // R8: error completion returns all ones
  a_r8_err_ones: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (rdata == ALL_ONES));
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master import mdio_pkg::*; #(
  parameter int HALF_PERIOD = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              no_phy,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int PCW = $clog2(HALF_PERIOD + 1);

  logic tick, accept, smp;
  req_t req_in;

  assign req_in = '{rd: rd_wr, phy: phy_addr, regad: reg_addr, wdata: wr_data};

  mdio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (mdio_i),
    .q   (smp)
  );

  mdc_tick_gen #(.HALF_PERIOD(HALF_PERIOD)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .run     (busy),
    .restart (accept),
    .tick    (tick)
  );

  mdio_frame_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .start   (start),
    .req_in  (req_in),
    .smp     (smp),
    .accept  (accept),
    .busy    (busy),
    .done    (done),
    .rdata   (rd_data),
    .err     (no_phy),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );

  // Phase-length monitor for the assertions: cycles mdc has held its level.
  logic           mdc_q, mdc_toggle;
  logic [PCW-1:0] ph_cnt;

  assign mdc_toggle = mdc ^ mdc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_q  <= 1'b1;
      ph_cnt <= '0;
    end else begin
      mdc_q  <= mdc;
      if (mdc_toggle)        ph_cnt <= PCW'(1);
      else if (ph_cnt != '1) ph_cnt <= ph_cnt + 1'b1;
    end
  end

  // R3: each completed phase inside a frame lasted HALF_PERIOD cycles
  a_r3_phase_len: assert property (@(posedge clk) disable iff (rst)
    (mdc_toggle && (mdc || $past(busy))) |-> (ph_cnt == PCW'(HALF_PERIOD)));
  // R4: pin values move only while mdc is low
  a_r4_change_low: assert property (@(posedge clk) disable iff (rst)
    !$stable({mdio_o, mdio_oe}) |-> !mdc);
  // R9: idle bus rests with mdc high and the line released
  a_r9_idle_rest: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (mdc && !mdio_oe));
endmodule

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  localparam int HP   = 4;
  localparam int NVEC = 7;
  // {read, phy present, phy addr, reg addr, data}
  localparam logic [27:0] VECS [0:NVEC-1] = '{
    {1'b0, 1'b1, 5'h01, 5'h00, 16'hA5C3},
    {1'b0, 1'b1, 5'h1F, 5'h1F, 16'hFFFF},
    {1'b1, 1'b1, 5'h10, 5'h02, 16'h1234},
    {1'b1, 1'b1, 5'h00, 5'h1F, 16'h8001},
    {1'b1, 1'b0, 5'h07, 5'h03, 16'h0000},
    {1'b0, 1'b1, 5'h15, 5'h0A, 16'h0000},
    {1'b1, 1'b1, 5'h0A, 5'h15, 16'h0000}
  };

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0, rd_wr = 1'b0;
  logic [4:0]  phy_addr = '0, reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic        mdio_i = 1'b1;
  logic        busy, done, no_phy, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;

  mdio_master #(.HALF_PERIOD(HP), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .start(start), .rd_wr(rd_wr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .rd_data(rd_data), .no_phy(no_phy),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0, r4_viol = 0, cap_n = 0;
  logic [1:0]  cap [0:127];
  logic        mdc_q = 1'b1;
  logic [1:0]  pins_q = 2'b01;
  bit          cur_rd = 0, cur_present = 1;
  logic [15:0] cur_rdata = '0, last_rd = '0;

  task automatic check_eq(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // PHY model: answers only reads while present
  function automatic logic phy_resp(input int k);
    if (!cur_rd || !cur_present) return 1'b1;
    if (k == 46) return 1'b0;
    if (k >= 47 && k <= 62) return cur_rdata[62 - k];
    return 1'b1;
  endfunction

  // Capture pins at each mdc rise, drive the PHY bit for that high phase
  always @(negedge clk) begin
    if (rst) begin
      mdc_q  = 1'b1;
      pins_q = {mdio_oe, mdio_o};
    end else begin
      if (mdc && mdc_q && ({mdio_oe, mdio_o} != pins_q)) r4_viol++;
      if (mdc && !mdc_q) begin
        if (cap_n < 128) cap[cap_n] = {mdio_oe, mdio_o};
        mdio_i = phy_resp(cap_n);
        cap_n++;
      end
      mdc_q  = mdc;
      pins_q = {mdio_oe, mdio_o};
    end
  end

  task automatic run_txn(input bit rd, input bit present, input logic [4:0] pa,
                         input logic [4:0] ra, input logic [15:0] data, input int poke_at);
    int lat, exp_n, nbad;
    string lreq;
    logic [45:0] hdr;
    logic [17:0] wtail;
    @(negedge clk);
    cur_rd = rd; cur_present = present; cur_rdata = data; cap_n = 0;
    rd_wr = rd; phy_addr = pa; reg_addr = ra; wr_data = data; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    check_eq("R2", "busy after accept", busy, 1);
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
      if (lat == poke_at) begin
        start = 1'b1; rd_wr = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~data;
      end else start = 1'b0;
    end
    exp_n = (rd && !present) ? 79 : 65;
    lreq  = !rd ? "R6" : (present ? "R7" : "R8");
    check_eq(lreq, "accept-to-done cycles", lat - 1, 2 * HP * exp_n);
    check_eq(lreq, "mdc rising edges", cap_n, exp_n);
    check_eq("R2", "busy low with done", busy, 0);
    check_eq("R9", "rest state at done", {mdc, mdio_oe}, 2'b10);
    hdr = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra};
    nbad = 0;
    for (int k = 0; k < 46; k++) if (cap[k] != {1'b1, hdr[45 - k]}) nbad++;
    check_eq("R5", "header bit mismatches", nbad, 0);
    nbad = 0;
    if (!rd) begin
      wtail = {2'b10, data};
      for (int k = 46; k < 64; k++) if (cap[k] != {1'b1, wtail[63 - k]}) nbad++;
      if (cap[64][1] != 1'b0) nbad++;
      check_eq("R6", "write tail mismatches", nbad, 0);
      check_eq("R10", "no_phy after write", no_phy, 0);
      check_eq("R10", "rd_data kept by write", rd_data, last_rd);
    end else begin
      for (int k = 46; k < exp_n; k++) if (cap[k][1] != 1'b0) nbad++;
      check_eq(lreq, "driven cycles after turnaround", nbad, 0);
      if (present) begin
        check_eq("R7", "read data", rd_data, data);
        check_eq("R7", "no_phy on answered read", no_phy, 0);
        last_rd = data;
      end else begin
        check_eq("R8", "read data without PHY", rd_data, 16'hFFFF);
        check_eq("R8", "no_phy without PHY", no_phy, 1);
        last_rd = 16'hFFFF;
      end
    end
    @(negedge clk);
    check_eq("R2", "done one cycle", done, 0);
    check_eq("R2", "nothing queued", busy, 0);
    check_eq("R9", "idle rest", {mdc, mdio_oe}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1", "mdc after reset", mdc, 1);
    check_eq("R1", "mdio_oe after reset", mdio_oe, 0);
    check_eq("R1", "mdio_o after reset", mdio_o, 1);
    check_eq("R1", "busy/done after reset", {busy, done}, 0);
    check_eq("R1", "no_phy after reset", no_phy, 0);
    check_eq("R1", "rd_data after reset", rd_data, 0);

    for (int v = 0; v < NVEC; v++)
      run_txn(VECS[v][27], VECS[v][26], VECS[v][25:21], VECS[v][20:16], VECS[v][15:0], 0);

    // R3: phase lengths at the start of a frame
    begin
      int n_lo, n_hi;
      @(negedge clk);
      cur_rd = 0; cap_n = 0;
      rd_wr = 1'b0; phy_addr = 5'h03; reg_addr = 5'h04; wr_data = 16'h0F0F; start = 1'b1;
      @(negedge clk);
      start = 1'b0; n_lo = 0; n_hi = 0;
      while (mdc == 1'b0 && n_lo < 100) begin n_lo++; @(negedge clk); end
      while (mdc == 1'b1 && n_hi < 100) begin n_hi++; @(negedge clk); end
      check_eq("R3", "first low phase length", n_lo, HP);
      check_eq("R3", "first high phase length", n_hi, HP);
      while (!done && n_hi < 5000) begin n_hi++; @(negedge clk); end
    end

    // R2: start and new request fields while busy are ignored
    run_txn(1'b1, 1'b1, 5'h12, 5'h09, 16'h5A5A, 20);
    run_txn(1'b0, 1'b1, 5'h0C, 5'h11, 16'h3C96, 100);

    check_eq("R4", "pin changes while mdc high", r4_viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule